// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This unit sits between an external interrupt controller and a processor core. It decides whether the core should take an interrupt at an instruction boundary. It collects three kinds of request: a reset request, a non-maskable interrupt pulse, and a 3-bit pending-level code. The pending level is written by the controller whenever its own state changes. When the core signals an evaluation point, the unit compares the requests with the core's status word. That status word carries an interrupt-enable flag and a 3-bit level mask. The unit picks at most one request.

When it accepts an NMI or a level interrupt, the unit returns a one-cycle acceptance record to the core. The record holds:
- a context-save request: old PC, old status word, their two stack addresses and the new stack pointer;
- the rewritten status word;
- the branch target.

A level acceptance also produces an acknowledge carrying the accepted level. The branch target of a level interrupt is a fixed base plus a 16-bit offset. The offset is read from one of seven vector registers, which software programs through a small 16-bit register port.

Top module: `irq_accept_unit`

## Requirements
- R1: At an evaluation (`eval_i`=1) the unit takes at most one request. A latched reset request wins over a latched NMI, and an NMI wins over a level interrupt. `take_kind_o` encodes the choice as 0 none, 1 reset, 2 NMI, 3 level.
- R2: An `nmi_i` pulse sets a sticky latch, which is cleared only when the NMI is taken. Taking an NMI branches to 0x40000008 and clears the enable flag, status bit 11, in the new status word. All other status bits are kept.
- R3: A level interrupt is taken only when the enable flag (status bit 11) is 1 and the pending level is numerically below the mask field (status bits 10:8).
- R4: On level acceptance the new status word has bit 11 cleared and bits 10:8 set to the accepted level, with the other bits unchanged. The target is 0x40000000 plus the vector register of that level.
- R5: A level acceptance raises `ack_valid_o` for one cycle, with `ack_level_o` equal to the accepted level. No other acceptance raises it.
- R6: Acceptance never clears the pending level. The level changes only on a `level_set_i` strobe, and the value 7 means nothing is pending.
- R7: For NMI and level acceptance, `save_en_o`=1 with:
  - the PC at SP-4;
  - the status word at SP-8;
  - new SP = SP-8.

  A reset acceptance has `save_en_o`=0.
- R8: Reads (16-bit `reg_rdata_o`, bit 0 = least significant bit of the low byte) return vector register i at offset 4*i for i=0..6. They return the memory-control value 0x0003 at offset 0x20 and the mode value 0x0010 at offset 0x40. Every other offset returns 0.
- R9: A write with size code 1 (16-bit; codes 0 byte, 2 word) changes only a vector register at its offset. Writes to any other offset are ignored.
- R10: A write with a size code other than 1 sets `wr_err_o` for exactly one cycle and changes no register.
- R11: After `rst`, the pending level is 7, all vector registers are 0, both latches are clear, and all acceptance outputs are 0.
- R12: Taking a reset request gives target 0x40000000 and new status word 0. It clears the NMI latch and all vector registers.
- R13: The acceptance outputs are registered. They are valid only in the cycle after the evaluation and are all zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req_i | input | 1 | Reset request pulse (latched) |
| nmi_i | input | 1 | Non-maskable interrupt pulse (latched) |
| level_set_i | input | 1 | Strobe loading a new pending level |
| level_i | input | 3 | Pending level from the controller, 7 = none |
| eval_i | input | 1 | Core is at an evaluation point |
| psw_i | input | 16 | Core status word (bit 11 enable, bits 10:8 mask) |
| pc_i | input | 32 | Core PC to be saved |
| sp_i | input | 32 | Core stack pointer |
| reg_wr_i | input | 1 | Register write strobe |
| reg_size_i | input | 2 | Write size code: 0 byte, 1 half, 2 word |
| reg_addr_i | input | 7 | Register offset within the block |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` (combinational) |
| wr_err_o | output | 1 | One-cycle illegal-size write flag |
| take_o | output | 1 | An acceptance record is valid |
| take_kind_o | output | 2 | Kind of accepted request |
| save_en_o | output | 1 | Context save requested |
| save_pc_o | output | 32 | PC to store |
| save_psw_o | output | 16 | Status word to store |
| save_pc_addr_o | output | 32 | Address for the PC (SP-4) |
| save_psw_addr_o | output | 32 | Address for the status word (SP-8) |
| new_sp_o | output | 32 | Updated stack pointer |
| new_psw_o | output | 16 | Updated status word |
| target_o | output | 32 | Branch target |
| ack_valid_o | output | 1 | Level acknowledge strobe |
| ack_level_o | output | 3 | Accepted level |

## Verification
The hardest situation to reach from the ports is a contention between all three request kinds in one evaluation, followed by evidence of what each acceptance left behind. The bench arranges it in three steps:
1. It latches a reset request, an NMI and a pending level before a single evaluation, and checks that the reset wins.
2. It evaluates again with no new pulses. A level acceptance through vector 0 then shows that the reset acceptance cleared both the NMI latch and the vectors.
3. It takes an NMI ahead of a pending level, then evaluates twice more. Two level acceptances in a row show that acceptance never consumed the level.

A table of status-word and level pairs covers the mask and enable comparison on both sides of each boundary.

// File: rtl/irq_accept_pkg.sv
`timescale 1ns/1ps
package irq_accept_pkg;

    localparam int XLEN      = 32;
    localparam int HALF_W    = 16;
    localparam int LVL_W     = 3;
    localparam int PSW_IE    = 11;
    localparam int PSW_LM_LO = 8;
    localparam logic [LVL_W-1:0] LVL_NONE = 3'd7;

    typedef enum logic [1:0] {
        TAKE_NONE  = 2'd0,
        TAKE_RESET = 2'd1,
        TAKE_NMI   = 2'd2,
        TAKE_LEVEL = 2'd3
    } take_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic [HALF_W-1:0] psw;
        logic [XLEN-1:0]   pc_addr;
        logic [XLEN-1:0]   psw_addr;
        logic [XLEN-1:0]   new_sp;
    } save_req_t;

    typedef struct packed {
        take_kind_e        kind;
        logic              save_en;
        save_req_t         save;
        logic [HALF_W-1:0] new_psw;
        logic [XLEN-1:0]   target;
        logic [LVL_W-1:0]  level;
    } accept_t;

    function automatic logic [LVL_W-1:0] psw_mask(input logic [HALF_W-1:0] psw);
        return psw[PSW_LM_LO +: LVL_W];
    endfunction

    function automatic logic level_allowed(input logic [HALF_W-1:0] psw,
                                           input logic [LVL_W-1:0]  lvl);
        return psw[PSW_IE] && (lvl < psw_mask(psw));
    endfunction

    function automatic logic [HALF_W-1:0] psw_on_level(input logic [HALF_W-1:0] psw,
                                                       input logic [LVL_W-1:0]  lvl);
        logic [HALF_W-1:0] p;
        p = psw;
        p[PSW_IE] = 1'b0;
        p[PSW_LM_LO +: LVL_W] = lvl;
        return p;
    endfunction

    function automatic logic [HALF_W-1:0] psw_on_nmi(input logic [HALF_W-1:0] psw);
        logic [HALF_W-1:0] p;
        p = psw;
        p[PSW_IE] = 1'b0;
        return p;
    endfunction

endpackage

// File: rtl/irq_req_latch.sv
`timescale 1ns/1ps
module irq_req_latch
    import irq_accept_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reset_req_i,
    input  logic             nmi_i,
    input  logic             level_set_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             clr_reset_i,
    input  logic             clr_nmi_i,
    output logic             reset_pend_o,
    output logic             nmi_pend_o,
    output logic [LVL_W-1:0] level_o
);

    logic             reset_q;
    logic             nmi_q;
    logic [LVL_W-1:0] level_q;

    // A pulse arriving in the cycle of acceptance re-arms the latch.
    always_ff @(posedge clk) begin
        if (rst) begin
            reset_q <= 1'b0;
            nmi_q   <= 1'b0;
            level_q <= LVL_NONE;
        end else begin
            reset_q <= reset_req_i | (reset_q & ~clr_reset_i);
            nmi_q   <= nmi_i | (nmi_q & ~clr_nmi_i);
            if (level_set_i) begin
                level_q <= level_i;
            end
        end
    end

    assign reset_pend_o = reset_q;
    assign nmi_pend_o   = nmi_q;
    assign level_o      = level_q;

endmodule

// File: rtl/irq_vec_regs.sv
`timescale 1ns/1ps
module irq_vec_regs
    import irq_accept_pkg::*;
#(
    parameter int                NUM_VEC    = 7,
    parameter int                ADDR_W     = 7,
    parameter int                VEC_STRIDE = 4,
    parameter logic [ADDR_W-1:0] MEMCTL_OFF = 7'h20,
    parameter logic [ADDR_W-1:0] MODE_OFF   = 7'h40,
    parameter logic [HALF_W-1:0] MEMCTL_VAL = 16'h0003,
    parameter logic [HALF_W-1:0] MODE_VAL   = 16'h0010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [HALF_W-1:0] wdata_i,
    input  logic              clear_i,
    input  logic [LVL_W-1:0]  sel_i,
    output logic [HALF_W-1:0] vec_o,
    output logic [HALF_W-1:0] rdata_o,
    output logic              wr_err_o
);

    logic [HALF_W-1:0] vec_q [NUM_VEC];
    logic              legal_wr;
    logic              err_q;

    assign legal_wr = wr_i && (acc_size_e'(size_i) == SZ_HALF);

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
        localparam logic [ADDR_W-1:0] OFF = ADDR_W'(i * VEC_STRIDE);
        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                vec_q[i] <= '0;
            end else if (legal_wr && (addr_i == OFF)) begin
                vec_q[i] <= wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= wr_i && !legal_wr;
        end
    end
    assign wr_err_o = err_q;

    always_comb begin
        vec_o = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (sel_i == LVL_W'(i)) begin
                vec_o = vec_q[i];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == MEMCTL_OFF) begin
            rdata_o = MEMCTL_VAL;
        end else if (addr_i == MODE_OFF) begin
            rdata_o = MODE_VAL;
        end else begin
            for (int i = 0; i < NUM_VEC; i++) begin
                if (addr_i == ADDR_W'(i * VEC_STRIDE)) begin
                    rdata_o = vec_q[i];
                end
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
    import irq_accept_pkg::*;
#(
    parameter logic [XLEN-1:0] VEC_BASE     = 32'h4000_0000,
    parameter logic [XLEN-1:0] NMI_TARGET   = 32'h4000_0008,
    parameter logic [XLEN-1:0] RESET_TARGET = 32'h4000_0000,
    parameter int              FRAME_PC     = 4,
    parameter int              FRAME_PSW    = 8
) (
    input  logic              eval_i,
    input  logic              reset_pend_i,
    input  logic              nmi_pend_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [HALF_W-1:0] psw_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   sp_i,
    input  logic [HALF_W-1:0] vec_i,
    output accept_t           acc_o
);

    take_kind_e kind;

    always_comb begin
        if (!eval_i) begin
            kind = TAKE_NONE;
        end else if (reset_pend_i) begin
            kind = TAKE_RESET;
        end else if (nmi_pend_i) begin
            kind = TAKE_NMI;
        end else if (level_allowed(psw_i, level_i)) begin
            kind = TAKE_LEVEL;
        end else begin
            kind = TAKE_NONE;
        end
    end

    always_comb begin
        acc_o               = '0;
        acc_o.kind          = kind;
        acc_o.save.pc       = pc_i;
        acc_o.save.psw      = psw_i;
        acc_o.save.pc_addr  = sp_i - XLEN'(FRAME_PC);
        acc_o.save.psw_addr = sp_i - XLEN'(FRAME_PSW);
        acc_o.save.new_sp   = sp_i - XLEN'(FRAME_PSW);
        case (kind)
            TAKE_RESET: begin
                acc_o.save    = '0;
                acc_o.new_psw = '0;
                acc_o.target  = RESET_TARGET;
            end
            TAKE_NMI: begin
                acc_o.save_en = 1'b1;
                acc_o.new_psw = psw_on_nmi(psw_i);
                acc_o.target  = NMI_TARGET;
            end
            TAKE_LEVEL: begin
                acc_o.save_en = 1'b1;
                acc_o.new_psw = psw_on_level(psw_i, level_i);
                acc_o.target  = VEC_BASE + {{(XLEN-HALF_W){1'b0}}, vec_i};
                acc_o.level   = level_i;
            end
            default: begin
                acc_o.save = '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_accept_unit.sv
`timescale 1ns/1ps
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int                NUM_VEC      = 7,
    parameter int                ADDR_W       = 7,
    parameter logic [XLEN-1:0]   VEC_BASE     = 32'h4000_0000,
    parameter logic [XLEN-1:0]   NMI_TARGET   = 32'h4000_0008,
    parameter logic [XLEN-1:0]   RESET_TARGET = 32'h4000_0000,
    parameter logic [HALF_W-1:0] MEMCTL_VAL   = 16'h0003,
    parameter logic [HALF_W-1:0] MODE_VAL     = 16'h0010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reset_req_i,
    input  logic              nmi_i,
    input  logic              level_set_i,
    input  logic [2:0]        level_i,
    input  logic              eval_i,
    input  logic [15:0]       psw_i,
    input  logic [31:0]       pc_i,
    input  logic [31:0]       sp_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_size_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic              wr_err_o,
    output logic              take_o,
    output logic [1:0]        take_kind_o,
    output logic              save_en_o,
    output logic [31:0]       save_pc_o,
    output logic [15:0]       save_psw_o,
    output logic [31:0]       save_pc_addr_o,
    output logic [31:0]       save_psw_addr_o,
    output logic [31:0]       new_sp_o,
    output logic [15:0]       new_psw_o,
    output logic [31:0]       target_o,
    output logic              ack_valid_o,
    output logic [2:0]        ack_level_o
);

    logic             reset_pend;
    logic             nmi_pend;
    logic [LVL_W-1:0] level_pend;
    logic [HALF_W-1:0] sel_vec;
    accept_t          acc;
    accept_t          acc_q;
    logic             took_reset;
    logic             took_nmi;

    assign took_reset = (acc.kind == TAKE_RESET);
    assign took_nmi   = (acc.kind == TAKE_NMI) || took_reset;

    irq_req_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .reset_req_i  (reset_req_i),
        .nmi_i        (nmi_i),
        .level_set_i  (level_set_i),
        .level_i      (level_i),
        .clr_reset_i  (took_reset),
        .clr_nmi_i    (took_nmi),
        .reset_pend_o (reset_pend),
        .nmi_pend_o   (nmi_pend),
        .level_o      (level_pend)
    );

    irq_vec_regs #(
        .NUM_VEC    (NUM_VEC),
        .ADDR_W     (ADDR_W),
        .MEMCTL_VAL (MEMCTL_VAL),
        .MODE_VAL   (MODE_VAL)
    ) u_vec (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (reg_wr_i),
        .size_i   (reg_size_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .clear_i  (took_reset),
        .sel_i    (level_pend),
        .vec_o    (sel_vec),
        .rdata_o  (reg_rdata_o),
        .wr_err_o (wr_err_o)
    );

    irq_arbiter #(
        .VEC_BASE     (VEC_BASE),
        .NMI_TARGET   (NMI_TARGET),
        .RESET_TARGET (RESET_TARGET)
    ) u_arb (
        .eval_i       (eval_i),
        .reset_pend_i (reset_pend),
        .nmi_pend_i   (nmi_pend),
        .level_i      (level_pend),
        .psw_i        (psw_i),
        .pc_i         (pc_i),
        .sp_i         (sp_i),
        .vec_i        (sel_vec),
        .acc_o        (acc)
    );

    always_ff @(posedge clk) begin
        if (rst || (acc.kind == TAKE_NONE)) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc;
        end
    end

    assign take_o          = (acc_q.kind != TAKE_NONE);
    assign take_kind_o     = acc_q.kind;
    assign save_en_o       = acc_q.save_en;
    assign save_pc_o       = acc_q.save.pc;
    assign save_psw_o      = acc_q.save.psw;
    assign save_pc_addr_o  = acc_q.save.pc_addr;
    assign save_psw_addr_o = acc_q.save.psw_addr;
    assign new_sp_o        = acc_q.save.new_sp;
    assign new_psw_o       = acc_q.new_psw;
    assign target_o        = acc_q.target;
    assign ack_valid_o     = (acc_q.kind == TAKE_LEVEL);
    assign ack_level_o     = acc_q.level;

endmodule

// File: rtl/irq_accept_chk.sv
`timescale 1ns/1ps
module irq_accept_chk
    import irq_accept_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        eval_i,
    input logic [15:0] psw_i,
    input logic [31:0] sp_i,
    input logic        reg_wr_i,
    input logic [1:0]  reg_size_i,
    input logic        wr_err_o,
    input logic        take_o,
    input logic [1:0]  take_kind_o,
    input logic        save_en_o,
    input logic [31:0] save_pc_addr_o,
    input logic [31:0] save_psw_addr_o,
    input logic [31:0] new_sp_o,
    input logic [15:0] new_psw_o,
    input logic [31:0] target_o,
    input logic        ack_valid_o,
    input logic [2:0]  ack_level_o
);

    assert_take_after_eval_R13: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(eval_i));

    assert_ack_only_level_R5: assert property (@(posedge clk) disable iff (rst)
        ack_valid_o |-> (take_o && take_kind_o == 2'd3 && new_psw_o[10:8] == ack_level_o));

    assert_level_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (take_o && take_kind_o == 2'd3) |->
            ($past(psw_i[11]) && (ack_level_o < $past(psw_i[10:8]))));

    assert_nmi_target_R2: assert property (@(posedge clk) disable iff (rst)
        (take_o && take_kind_o == 2'd2) |-> (target_o == 32'h4000_0008 && !new_psw_o[11]));

    assert_frame_R7: assert property (@(posedge clk) disable iff (rst)
        save_en_o |-> (new_sp_o == $past(sp_i) - 32'd8 &&
                       save_psw_addr_o == $past(sp_i) - 32'd8 &&
                       save_pc_addr_o == $past(sp_i) - 32'd4));

    assert_reset_nosave_R12: assert property (@(posedge clk) disable iff (rst)
        (take_o && take_kind_o == 2'd1) |-> (!save_en_o && new_psw_o == 16'h0));

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (rst)
        wr_err_o |-> ($past(reg_wr_i) && $past(reg_size_i) != 2'd1));

    assert_idle_zero_R13: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (!save_en_o && !ack_valid_o && target_o == 32'h0));

endmodule

bind irq_accept_unit irq_accept_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .eval_i          (eval_i),
    .psw_i           (psw_i),
    .sp_i            (sp_i),
    .reg_wr_i        (reg_wr_i),
    .reg_size_i      (reg_size_i),
    .wr_err_o        (wr_err_o),
    .take_o          (take_o),
    .take_kind_o     (take_kind_o),
    .save_en_o       (save_en_o),
    .save_pc_addr_o  (save_pc_addr_o),
    .save_psw_addr_o (save_psw_addr_o),
    .new_sp_o        (new_sp_o),
    .new_psw_o       (new_psw_o),
    .target_o        (target_o),
    .ack_valid_o     (ack_valid_o),
    .ack_level_o     (ack_level_o)
);

// File: tb/test_irq_accept_unit.sv
`timescale 1ns/1ps
module test_irq_accept_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        reset_req_i, nmi_i, level_set_i, eval_i, reg_wr_i;
    logic [2:0]  level_i;
    logic [15:0] psw_i, reg_wdata_i;
    logic [31:0] pc_i, sp_i;
    logic [1:0]  reg_size_i;
    logic [6:0]  reg_addr_i;
    logic [15:0] reg_rdata_o, save_psw_o, new_psw_o;
    logic        wr_err_o, take_o, save_en_o, ack_valid_o;
    logic [1:0]  take_kind_o;
    logic [31:0] save_pc_o, save_pc_addr_o, save_psw_addr_o, new_sp_o, target_o;
    logic [2:0]  ack_level_o;

    always #2.5 clk = ~clk;

    irq_accept_unit i_irq_accept_unit (
        .clk(clk), .rst(rst), .reset_req_i(reset_req_i), .nmi_i(nmi_i),
        .level_set_i(level_set_i), .level_i(level_i), .eval_i(eval_i),
        .psw_i(psw_i), .pc_i(pc_i), .sp_i(sp_i), .reg_wr_i(reg_wr_i),
        .reg_size_i(reg_size_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .wr_err_o(wr_err_o), .take_o(take_o),
        .take_kind_o(take_kind_o), .save_en_o(save_en_o), .save_pc_o(save_pc_o),
        .save_psw_o(save_psw_o), .save_pc_addr_o(save_pc_addr_o),
        .save_psw_addr_o(save_psw_addr_o), .new_sp_o(new_sp_o),
        .new_psw_o(new_psw_o), .target_o(target_o), .ack_valid_o(ack_valid_o),
        .ack_level_o(ack_level_o)
    );

    int checks = 0;
    int errors = 0;
    logic [15:0] vec_model [7];

    typedef struct packed {
        logic [2:0]  lvl;
        logic [15:0] psw;
        logic        take;
    } lvl_case_t;

    // status: bit 11 enable, bits 10:8 mask
    localparam lvl_case_t CASES [9] = '{
        '{3'd3, 16'h0FA5, 1'b1},   // mask 7, enabled
        '{3'd3, 16'h0BA5, 1'b0},   // equal to mask
        '{3'd3, 16'h0C5A, 1'b1},   // one below mask 4
        '{3'd0, 16'h0712, 1'b0},   // enable clear
        '{3'd6, 16'h0F00, 1'b1},   // highest real level
        '{3'd7, 16'h0FFF, 1'b0},   // 7: none pending
        '{3'd0, 16'h0900, 1'b1},   // mask 1
        '{3'd0, 16'h0800, 1'b0},   // mask 0 blocks all
        '{3'd5, 16'h8E01, 1'b1}    // upper bits kept
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        reset_req_i = 0; nmi_i = 0; level_set_i = 0; eval_i = 0; reg_wr_i = 0;
    endtask

    task automatic set_level(input logic [2:0] l);
        @(negedge clk); level_set_i = 1; level_i = l;
        @(negedge clk); level_set_i = 0;
    endtask

    task automatic pulse_nmi();
        @(negedge clk); nmi_i = 1;
        @(negedge clk); nmi_i = 0;
    endtask

    task automatic pulse_reset_req();
        @(negedge clk); reset_req_i = 1;
        @(negedge clk); reset_req_i = 0;
    endtask

    task automatic evaluate(input logic [15:0] psw, input logic [31:0] pc, input logic [31:0] sp);
        @(negedge clk); eval_i = 1; psw_i = psw; pc_i = pc; sp_i = sp;
        @(negedge clk); eval_i = 0;
    endtask

    task automatic expect_level(input string req, input logic [2:0] l,
                                input logic [15:0] psw, input logic [31:0] pc,
                                input logic [31:0] sp);
        logic [15:0] np;
        np = psw; np[11] = 1'b0; np[10:8] = l;
        chk(req, "take", {31'd0, take_o}, 32'd1);
        chk(req, "kind", {30'd0, take_kind_o}, 32'd3);
        chk(req, "target", target_o, 32'h4000_0000 + {16'd0, vec_model[l]});
        chk(req, "new_psw", {16'd0, new_psw_o}, {16'd0, np});
        chk("R5", "ack", {28'd0, ack_valid_o, ack_level_o}, {28'd0, 1'b1, l});
        chk("R7", "save_pc", save_pc_o, pc);
        chk("R7", "save_psw", {16'd0, save_psw_o}, {16'd0, psw});
        chk("R7", "frame", {save_pc_addr_o ^ save_psw_addr_o, new_sp_o},
            {(sp - 32'd4) ^ (sp - 32'd8), sp - 32'd8});
    endtask

    task automatic expect_none(input string req);
        chk(req, "no take", {29'd0, take_o, take_kind_o}, 32'd0);
        chk(req, "no ack", {31'd0, ack_valid_o}, 32'd0);
    endtask

    task automatic reg_write(input logic [6:0] a, input logic [1:0] sz, input logic [15:0] d);
        @(negedge clk); reg_wr_i = 1; reg_addr_i = a; reg_size_i = sz; reg_wdata_i = d;
        @(negedge clk); reg_wr_i = 0;
    endtask

    task automatic reg_read(input string req, input logic [6:0] a, input logic [15:0] exp);
        @(negedge clk); reg_addr_i = a;
        #1 chk(req, "rdata", {16'd0, reg_rdata_o}, {16'd0, exp});
    endtask

    initial begin
        #(5 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        level_i = 0; psw_i = 0; pc_i = 0; sp_i = 0;
        reg_size_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R11: reset state
        chk("R11", "take after reset", {30'd0, take_o, save_en_o}, 32'd0);
        reg_read("R11", 7'h08, 16'h0000);
        evaluate(16'h0F00, 32'h100, 32'h2000);
        expect_none("R11");

        // R8 / R9: program vectors, read map
        for (int i = 0; i < 7; i++) begin
            vec_model[i] = 16'h1000 + 16'(i) * 16'h0111;
            reg_write(7'(i * 4), 2'd1, vec_model[i]);
        end
        for (int i = 0; i < 7; i++) reg_read("R8", 7'(i * 4), vec_model[i]);
        reg_read("R8", 7'h20, 16'h0003);
        reg_read("R8", 7'h40, 16'h0010);
        reg_read("R8", 7'h1C, 16'h0000);
        reg_read("R8", 7'h02, 16'h0000);
        reg_write(7'h20, 2'd1, 16'hBEEF);
        chk("R9", "ignored write err", {31'd0, wr_err_o}, 32'd0);
        reg_read("R9", 7'h20, 16'h0003);
        reg_read("R9", 7'h1C, 16'h0000);

        // R10: illegal sizes
        reg_write(7'h04, 2'd0, 16'hDEAD);
        chk("R10", "err byte", {31'd0, wr_err_o}, 32'd1);
        @(negedge clk);
        chk("R10", "err one cycle", {31'd0, wr_err_o}, 32'd0);
        reg_write(7'h04, 2'd2, 16'hDEAD);
        chk("R10", "err word", {31'd0, wr_err_o}, 32'd1);
        reg_read("R10", 7'h04, vec_model[1]);

        // R3 / R4: table walk
        for (int k = 0; k < 9; k++) begin
            set_level(CASES[k].lvl);
            evaluate(CASES[k].psw, 32'h0000_1000 + 32'(k), 32'h0000_8000 + 32'(k * 16));
            if (CASES[k].take)
                expect_level("R4", CASES[k].lvl, CASES[k].psw,
                             32'h0000_1000 + 32'(k), 32'h0000_8000 + 32'(k * 16));
            else
                expect_none("R3");
        end

        // R13: outputs clear the cycle after
        @(negedge clk);
        expect_none("R13");

        // R2 / R1: NMI over pending level; R13 no take without eval
        set_level(3'd2);
        pulse_nmi();
        @(negedge clk);
        expect_none("R13");
        evaluate(16'h0F33, 32'h0000_4444, 32'h0000_9000);
        chk("R1", "kind nmi", {30'd0, take_kind_o}, 32'd2);
        chk("R2", "nmi target", target_o, 32'h4000_0008);
        chk("R2", "nmi psw", {16'd0, new_psw_o}, 32'h0000_0733);
        chk("R7", "nmi frame", {new_sp_o ^ save_pc_addr_o}, 32'h8FF8 ^ 32'h8FFC);
        chk("R5", "no ack on nmi", {31'd0, ack_valid_o}, 32'd0);

        // R6: level stays pending across acceptances, NMI consumed
        evaluate(16'h0F33, 32'h0000_5555, 32'h0000_9000);
        expect_level("R6", 3'd2, 16'h0F33, 32'h0000_5555, 32'h0000_9000);
        evaluate(16'h0B00, 32'h0000_6666, 32'h0000_A000);
        expect_level("R6", 3'd2, 16'h0B00, 32'h0000_6666, 32'h0000_A000);

        // R12 / R1: reset beats NMI and level, clears both
        pulse_nmi();
        pulse_reset_req();
        evaluate(16'h0F00, 32'h0000_7777, 32'h0000_B000);
        chk("R1", "kind reset", {30'd0, take_kind_o}, 32'd1);
        chk("R12", "reset target", target_o, 32'h4000_0000);
        chk("R12", "reset psw/save", {15'd0, save_en_o, new_psw_o}, 32'd0);
        for (int i = 0; i < 7; i++) vec_model[i] = 16'h0000;
        reg_read("R12", 7'h08, 16'h0000);
        evaluate(16'h0F00, 32'h0000_8888, 32'h0000_B000);
        expect_level("R12", 3'd2, 16'h0F00, 32'h0000_8888, 32'h0000_B000);

        idle();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule